// File: doc/BRIEF.md
# Bus-Shared Multi-Cycle Register Processor

This block is a small execution engine. It holds four general registers of `DATA_W` bits, an operand latch, a result latch and an arithmetic/logic unit, all linked by one shared internal bus. A strobe on `w` hands it a 7-bit instruction. The engine then runs the instruction over one or three cycles and pulses `done` as it finishes. The bus is a wide OR of gated sources, and at most one source is gated onto it at any time. The bus is also brought out on `bus_q`, so a caller can watch the value that moves in each cycle.

The controller only raises a generic register write, a generic register read and a select between the two register fields. Two small decoders turn these into per-register enables. A caller reads a register by issuing a move of that register onto itself. In the cycle where `done` is high, `bus_q` then shows the register's value, and the register keeps that value.

Top module: `mcpu_core`

## Requirements
- R1: After reset `done` is 0, `bus_q` is 0, and all four general registers read back as 0.
- R2: An instruction is taken from `fun` on a clock edge where the engine is idle and `w` is 1. Bits [1:0] of `fun` name the target register X, bits [3:2] name the source register Y, and bits [6:4] hold the opcode. Opcode 000 writes `data_in` into X. `done` is high in the first cycle after the edge that took the instruction, and during that cycle `bus_q` equals `data_in`.
- R3: Opcode 001 copies Y into X. It completes with `done` in the first cycle after the edge that took it, and during that cycle `bus_q` carries the value of Y.
- R4: Opcode 010 writes X+Y into X and opcode 011 writes X−Y into X. Both results wrap modulo 2^DATA_W.
- R5: Opcode 100 writes the bitwise inverse of X into X. Y is not used.
- R6: Opcodes 101, 110 and 111 write X AND Y, X OR Y and X XOR Y into X.
- R7: Opcodes 010 to 111 assert `done` in the third cycle after the edge that took the instruction. The register write takes effect at the end of that cycle.
- R8: A `w` strobe that arrives while an instruction is running is ignored. It changes no register and does not alter the running instruction.
- R9: `done` is high for exactly one cycle per instruction.
- R10: At most one source drives the bus in any cycle. When the engine is idle, `bus_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| w | input | 1 | Instruction strobe, sampled when idle |
| fun | input | 7 | Instruction: opcode[6:4], Y[3:2], X[1:0] |
| data_in | input | DATA_W | External operand for opcode 000 |
| done | output | 1 | One-cycle completion pulse |
| bus_q | output | DATA_W | Value on the shared internal bus |

## Verification
Assertions check on every cycle that at most one bus source is enabled, that at most one register is written or read, and that the bus is 0 when no source is active. They also check that `done` never lasts two cycles, that the held instruction stays unchanged while busy, and that a load puts the external operand on the bus. The arithmetic results, the wraparound, the latency of each opcode class and the fact that a strobe during execution has no effect can only be shown by the bench's scenarios. These scenarios compare register read-backs against a reference model after each directed and random instruction.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int OP_W    = 3;
  localparam int SEL_W   = 2;
  localparam int INSTR_W = OP_W + 2 * SEL_W;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 3'd0,
    OP_MOVE = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_INV  = 3'd4,
    OP_AND  = 3'd5,
    OP_OR   = 3'd6,
    OP_XOR  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_CALC,
    ST_WBACK
  } phase_e;

  typedef struct packed {
    op_e              op;
    logic [SEL_W-1:0] ry;
    logic [SEL_W-1:0] rx;
  } instr_t;
endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_INV:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mcpu_gpr_bank.sv
module mcpu_gpr_bank #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_any,
  input  logic              rd_any,
  input  logic              rd_sel_rx,
  input  logic [SEL_W-1:0]  rx,
  input  logic [SEL_W-1:0]  ry,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NUM = 1 << SEL_W;

  logic [NUM-1:0]    we_vec;
  logic [NUM-1:0]    oe_vec;
  logic [SEL_W-1:0]  rsel;
  logic [DATA_W-1:0] masked [NUM];

  assign rsel = rd_sel_rx ? rx : ry;

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign we_vec[g] = wr_any && (rx == SEL_W'(g));
    assign oe_vec[g] = rd_any && (rsel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (we_vec[g]) q <= wdata;
    end
    assign masked[g] = oe_vec[g] ? q : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++) rdata = rdata | masked[i];
  end

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
  p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_vec));
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               w,
  input  logic [INSTR_W-1:0] fun,
  output op_e                op,
  output logic [SEL_W-1:0]   rx,
  output logic [SEL_W-1:0]   ry,
  output logic               ext_oe,
  output logic               gpr_we,
  output logic               gpr_oe,
  output logic               rd_sel_rx,
  output logic               a_we,
  output logic               g_we,
  output logic               g_oe,
  output logic               done
);
  phase_e st_q, st_d;
  instr_t ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ir_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && w) ir_q <= instr_t'(fun);
    end
  end

  assign op = ir_q.op;
  assign rx = ir_q.rx;
  assign ry = ir_q.ry;

  always_comb begin
    st_d      = st_q;
    ext_oe    = 1'b0;
    gpr_we    = 1'b0;
    gpr_oe    = 1'b0;
    rd_sel_rx = 1'b0;
    a_we      = 1'b0;
    g_we      = 1'b0;
    g_oe      = 1'b0;
    done      = 1'b0;
    case (st_q)
      ST_IDLE: if (w) st_d = ST_EXEC;
      ST_EXEC: begin
        case (ir_q.op)
          OP_LOAD: begin
            ext_oe = 1'b1;
            gpr_we = 1'b1;
            done   = 1'b1;
            st_d   = ST_IDLE;
          end
          OP_MOVE: begin
            gpr_oe = 1'b1;
            gpr_we = 1'b1;
            done   = 1'b1;
            st_d   = ST_IDLE;
          end
          default: begin
            gpr_oe    = 1'b1;
            rd_sel_rx = 1'b1;
            a_we      = 1'b1;
            st_d      = ST_CALC;
          end
        endcase
      end
      ST_CALC: begin
        if (ir_q.op != OP_INV) gpr_oe = 1'b1;
        g_we = 1'b1;
        st_d = ST_WBACK;
      end
      default: begin
        g_oe   = 1'b1;
        gpr_we = 1'b1;
        done   = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
  end

  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(ir_q));
  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               w,
  input  logic [INSTR_W-1:0] fun,
  input  logic [DATA_W-1:0]  data_in,
  output logic               done,
  output logic [DATA_W-1:0]  bus_q
);
  op_e               op;
  logic [SEL_W-1:0]  rx, ry;
  logic              ext_oe, gpr_we, gpr_oe, rd_sel_rx, a_we, g_we, g_oe;
  logic [DATA_W-1:0] gpr_rd, a_q, g_q, alu_y, bus;

  mcpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .w(w), .fun(fun),
    .op(op), .rx(rx), .ry(ry),
    .ext_oe(ext_oe), .gpr_we(gpr_we), .gpr_oe(gpr_oe), .rd_sel_rx(rd_sel_rx),
    .a_we(a_we), .g_we(g_we), .g_oe(g_oe), .done(done)
  );

  mcpu_gpr_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_gpr (
    .clk(clk), .rst_n(rst_n), .wr_any(gpr_we), .rd_any(gpr_oe),
    .rd_sel_rx(rd_sel_rx), .rx(rx), .ry(ry), .wdata(bus), .rdata(gpr_rd)
  );

  mcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(a_q), .b(bus), .y(alu_y)
  );

  assign bus = ({DATA_W{ext_oe}} & data_in) | gpr_rd | ({DATA_W{g_oe}} & g_q);
  assign bus_q = bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      g_q <= '0;
    end else begin
      if (a_we) a_q <= bus;
      if (g_we) g_q <= alu_y;
    end
  end

  p_one_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_oe, gpr_oe, g_oe}));
  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_oe || gpr_oe || g_oe) |-> (bus_q == '0));
  p_load_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_LOAD) |-> (bus_q == data_in));
endmodule

// File: tb/mcpu_core_tb.sv
`timescale 1ns/1ps
module mcpu_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       w = 1'b0;
  logic [6:0] fun = '0;
  logic [7:0] data_in = '0;
  logic       done;
  logic [7:0] bus_q;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [4];

  always #2 clk = ~clk;

  mcpu_core #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .w(w), .fun(fun),
    .data_in(data_in), .done(done), .bus_q(bus_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_expect(input logic [2:0] op, input logic [7:0] x,
                                          input logic [7:0] y, input logic [7:0] d);
    case (op)
      3'd0: return d;
      3'd1: return y;
      3'd2: return x + y;
      3'd3: return x - y;
      3'd4: return ~x;
      3'd5: return x & y;
      3'd6: return x | y;
      default: return x ^ y;
    endcase
  endfunction

  // Runs one instruction; returns bus value at done and latency in cycles.
  task automatic run_instr(input logic [2:0] op, input logic [1:0] ry, input logic [1:0] rx,
                           input logic [7:0] d, input bit noise,
                           output logic [7:0] bus_v, output int lat);
    @(negedge clk);
    w = 1'b1; fun = {op, ry, rx}; data_in = d;
    @(negedge clk);
    w = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      if (noise && lat == 1) begin
        w = 1'b1; fun = 7'($urandom); data_in = 8'($urandom);
      end
      @(negedge clk);
      w = 1'b0;
      lat++;
    end
    chk(done == 1'b1, "R7 done seen", int'(done), 1);
    bus_v = bus_q;
    if (done) mdl[rx] = f_expect(op, mdl[rx], mdl[ry], d);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(bus_q == 8'd0, "R10 idle bus zero", int'(bus_q), 0);
  endtask

  task automatic read_reg(input logic [1:0] k, input string req);
    logic [7:0] v;
    int lat;
    run_instr(3'd1, k, k, 8'd0, 1'b0, v, lat);
    chk(v == mdl[k], req, int'(v), int'(mdl[k]));
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] ry, input logic [1:0] rx,
                       input logic [7:0] d, input bit noise, input string req);
    logic [7:0] v;
    int lat;
    int exp_lat;
    exp_lat = (op <= 3'd1) ? 1 : 3;
    run_instr(op, ry, rx, d, noise, v, lat);
    chk(lat == exp_lat, "R7 latency", lat, exp_lat);
    if (op == 3'd0) chk(v == d, "R2 bus shows data", int'(v), int'(d));
    read_reg(rx, req);
  endtask

  initial begin
    logic [7:0] v;
    int lat;
    for (int i = 0; i < 4; i++) mdl[i] = 8'd0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(bus_q == 8'd0, "R1 reset bus", int'(bus_q), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      run_instr(3'd1, 2'(k), 2'(k), 8'd0, 1'b0, v, lat);
      chk(v == 8'd0, "R1 reset register", int'(v), 0);
      chk(lat == 1, "R3 move latency", lat, 1);
    end
    do_op(3'd0, 2'd0, 2'd0, 8'd200, 1'b0, "R2 load");
    do_op(3'd0, 2'd0, 2'd1, 8'd100, 1'b0, "R2 load");
    do_op(3'd2, 2'd1, 2'd0, 8'd0, 1'b0, "R4 add wraps");
    chk(mdl[0] == 8'd44, "R4 add model", int'(mdl[0]), 44);
    do_op(3'd0, 2'd0, 2'd2, 8'd5, 1'b0, "R2 load");
    do_op(3'd0, 2'd0, 2'd3, 8'd10, 1'b0, "R2 load");
    do_op(3'd3, 2'd3, 2'd2, 8'd0, 1'b0, "R4 sub wraps");
    do_op(3'd4, 2'd0, 2'd3, 8'd0, 1'b0, "R5 invert");
    do_op(3'd5, 2'd0, 2'd3, 8'd0, 1'b0, "R6 and");
    do_op(3'd6, 2'd1, 2'd2, 8'd0, 1'b0, "R6 or");
    do_op(3'd7, 2'd2, 2'd1, 8'd0, 1'b0, "R6 xor");
    do_op(3'd1, 2'd3, 2'd0, 8'd0, 1'b0, "R3 move");
    do_op(3'd2, 2'd2, 2'd2, 8'd0, 1'b1, "R8 strobe while busy");
    for (int k = 0; k < 4; k++) read_reg(2'(k), "R8 registers untouched");
    for (int n = 0; n < 250; n++) begin
      logic [2:0] op;
      op = 3'($urandom);
      do_op(op, 2'($urandom), 2'($urandom), 8'($urandom), (op > 3'd1) && ($urandom % 3 == 0),
            "R6 random mix");
    end
    for (int k = 0; k < 4; k++) read_reg(2'(k), "R8 final registers");
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule